// File: doc/BRIEF.md
# Pipeline Hazard Forwarding Stall Unit

This unit makes the hazard decisions for a five-stage in-order integer pipeline. It looks at the source register numbers of the instruction in execute and the destination numbers and write flags of the two older instructions in memory and writeback. From these it chooses, for each ALU operand, where the value comes from: the register file, the memory-stage result or the writeback-stage result. A dependent instruction therefore gets its operand without waiting for writeback.

It also watches the instruction in decode. If that instruction reads the destination of a load that is in execute, forwarding cannot deliver the value in time. The unit then freezes the program counter and the fetch/decode register for one cycle, and a no-op bubble goes into execute in place of the stalled instruction.

Branches are resolved in decode, and fetch always assumes they are not taken. When decode reports a taken branch, the unit squashes the instruction that was fetched after the branch and redirects fetch to the branch target. A misprediction costs one cycle and a correct guess costs none. All outputs are combinational functions of the current inputs. The clock and reset feed only the attached property checker.

Top module: `hazardUnit`

## Requirements
- R1: An operand selects the memory-stage result, code 2'b10, when the memory-stage instruction writes a register, its destination is not register 0, and that destination equals the operand's source register.
- R2: An operand selects the writeback-stage result, code 2'b01, when the writeback-stage instruction writes a non-zero destination equal to the operand's source and the memory stage does not match under R1.
- R3: When both the memory stage and the writeback stage match the same source register, the memory-stage result (2'b10) wins.
- R4: An operand selects the register file, code 2'b00, when its source is register 0, when no producer matches, or when a matching producer has its write flag low.
- R5: Operand A (select fwdSelA) follows the execute-stage rs and operand B (fwdSelB) follows the execute-stage rt, each on its own.
- R6: A load-use stall occurs when the execute-stage instruction reads memory, its rt is non-zero, and that rt equals the decode-stage rs or rt. During the stall pcWriteEn=0, ifIdWriteEn=0 and idExBubble=1.
- R7: When no load-use stall is detected, pcWriteEn=1, ifIdWriteEn=1 and idExBubble=0. A load to register 0, or a non-load with a matching rt, causes no stall.
- R8: With no stall, a taken branch decision sets ifIdFlush=1 and pcTakeTarget=1. A not-taken decision leaves both at 0.
- R9: During a load-use stall the branch decision is ignored, and ifIdFlush and pcTakeTarget stay 0.
- R10: Forwarding selects do not depend on the stall or flush state: a load-use stall and a taken branch leave fwdSelA and fwdSelB unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the attached checker |
| rstN | input | 1 | Active-low reset for the attached checker |
| idExRs | input | AW | rs of the instruction in execute |
| idExRt | input | AW | rt of the instruction in execute (load destination) |
| idExMemRead | input | 1 | Execute-stage instruction is a load |
| exMemRd | input | AW | Destination of the memory-stage instruction |
| exMemRegWrite | input | 1 | Memory-stage instruction writes a register |
| memWbRd | input | AW | Destination of the writeback-stage instruction |
| memWbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| ifIdRs | input | AW | rs of the instruction in decode |
| ifIdRt | input | AW | rt of the instruction in decode |
| idBranchTaken | input | 1 | Decode resolved a branch as taken |
| fwdSelA | output | 2 | ALU operand A source select |
| fwdSelB | output | 2 | ALU operand B source select |
| pcWriteEn | output | 1 | Program counter may advance |
| ifIdWriteEn | output | 1 | Fetch/decode register may load |
| idExBubble | output | 1 | Load a no-op into execute |
| ifIdFlush | output | 1 | Squash the instruction in fetch/decode |
| pcTakeTarget | output | 1 | Load the branch target into the program counter |

## Verification
Every result of this unit is due in the same cycle as the inputs that cause it: the selects, the stall strobes and the squash strobes have no register between input and output. The bench therefore drives a full set of pipeline-register fields just after a falling edge and samples the outputs a few nanoseconds later, before the next rising edge. No result is looked for in a later cycle. Each scenario sets its own fields from a known idle pattern, so a value left over from an earlier scenario cannot satisfy a check.

// File: rtl/hazardPkg.sv
package hazardPkg;

  typedef enum logic [1:0] {
    FWD_REGFILE = 2'b00,
    FWD_WBACK   = 2'b01,
    FWD_MEMSTG  = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic freeze;    // hold PC and fetch/decode register
    logic bubble;    // insert no-op into execute
    logic squash;    // kill wrongly fetched instruction
    logic redirect;  // fetch from branch target
  } hazStrobe_t;

endpackage

// File: rtl/fwdPick.sv
module fwdPick #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] srcReg,
  input  logic [AW-1:0] exMemRd,
  input  logic          exMemRegWrite,
  input  logic [AW-1:0] memWbRd,
  input  logic          memWbRegWrite,
  output logic [1:0]    sel
);
  import hazardPkg::*;

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic srcLive;
  logic memHit;
  logic wbHit;

  assign srcLive = (srcReg != ZERO_REG);
  assign memHit  = srcLive && exMemRegWrite && (exMemRd == srcReg);
  assign wbHit   = srcLive && memWbRegWrite && (memWbRd == srcReg);

  always_comb begin
    if (memHit)      sel = FWD_MEMSTG;
    else if (wbHit)  sel = FWD_WBACK;
    else             sel = FWD_REGFILE;
  end
endmodule

// File: rtl/fwdDatapath.sv
module fwdDatapath #(
  parameter int AW     = 5,
  parameter int NUM_OP = 2
) (
  input  logic [NUM_OP*AW-1:0]  srcRegs,
  input  logic [AW-1:0]         exMemRd,
  input  logic                  exMemRegWrite,
  input  logic [AW-1:0]         memWbRd,
  input  logic                  memWbRegWrite,
  input  hazardPkg::hazStrobe_t strobes,
  output logic [NUM_OP*2-1:0]   selFlat,
  output logic                  pcWriteEn,
  output logic                  ifIdWriteEn,
  output logic                  idExBubble,
  output logic                  ifIdFlush,
  output logic                  pcTakeTarget
);
  localparam int SELW = 2;

  for (genvar op = 0; op < NUM_OP; op++) begin : g_op
    fwdPick #(.AW(AW)) u_pick (
      .srcReg        (srcRegs[op*AW +: AW]),
      .exMemRd       (exMemRd),
      .exMemRegWrite (exMemRegWrite),
      .memWbRd       (memWbRd),
      .memWbRegWrite (memWbRegWrite),
      .sel           (selFlat[op*SELW +: SELW])
    );
  end

  assign pcWriteEn    = !strobes.freeze;
  assign ifIdWriteEn  = !strobes.freeze;
  assign idExBubble   = strobes.bubble;
  assign ifIdFlush    = strobes.squash;
  assign pcTakeTarget = strobes.redirect;
endmodule

// File: rtl/hazardCtrl.sv
module hazardCtrl #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]         idExRt,
  input  logic                  idExMemRead,
  input  logic [AW-1:0]         ifIdRs,
  input  logic [AW-1:0]         ifIdRt,
  input  logic                  idBranchTaken,
  output hazardPkg::hazStrobe_t strobes
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic loadDestLive;
  logic loadUse;

  assign loadDestLive = idExMemRead && (idExRt != ZERO_REG);
  assign loadUse      = loadDestLive && ((idExRt == ifIdRs) || (idExRt == ifIdRt));

  always_comb begin
    strobes.freeze   = loadUse;
    strobes.bubble   = loadUse;
    strobes.squash   = idBranchTaken && !loadUse;
    strobes.redirect = idBranchTaken && !loadUse;
  end
endmodule

// File: rtl/hazardUnit.sv
module hazardUnit #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] idExRs,
  input  logic [AW-1:0] idExRt,
  input  logic          idExMemRead,
  input  logic [AW-1:0] exMemRd,
  input  logic          exMemRegWrite,
  input  logic [AW-1:0] memWbRd,
  input  logic          memWbRegWrite,
  input  logic [AW-1:0] ifIdRs,
  input  logic [AW-1:0] ifIdRt,
  input  logic          idBranchTaken,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          pcWriteEn,
  output logic          ifIdWriteEn,
  output logic          idExBubble,
  output logic          ifIdFlush,
  output logic          pcTakeTarget
);
  localparam int NUM_OP = 2;

  hazardPkg::hazStrobe_t strobes;
  logic [NUM_OP*2-1:0]   selFlat;

  hazardCtrl #(.AW(AW)) u_ctrl (
    .idExRt        (idExRt),
    .idExMemRead   (idExMemRead),
    .ifIdRs        (ifIdRs),
    .ifIdRt        (ifIdRt),
    .idBranchTaken (idBranchTaken),
    .strobes       (strobes)
  );

  fwdDatapath #(.AW(AW), .NUM_OP(NUM_OP)) u_dp (
    .srcRegs       ({idExRt, idExRs}),
    .exMemRd       (exMemRd),
    .exMemRegWrite (exMemRegWrite),
    .memWbRd       (memWbRd),
    .memWbRegWrite (memWbRegWrite),
    .strobes       (strobes),
    .selFlat       (selFlat),
    .pcWriteEn     (pcWriteEn),
    .ifIdWriteEn   (ifIdWriteEn),
    .idExBubble    (idExBubble),
    .ifIdFlush     (ifIdFlush),
    .pcTakeTarget  (pcTakeTarget)
  );

  assign fwdSelA = selFlat[1:0];
  assign fwdSelB = selFlat[3:2];
endmodule

// File: rtl/hazardUnitChk.sv
module hazardUnitChk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] idExRs,
  input logic [AW-1:0] idExRt,
  input logic          idExMemRead,
  input logic [AW-1:0] exMemRd,
  input logic          exMemRegWrite,
  input logic [AW-1:0] memWbRd,
  input logic          memWbRegWrite,
  input logic [AW-1:0] ifIdRs,
  input logic [AW-1:0] ifIdRt,
  input logic          idBranchTaken,
  input logic [1:0]    fwdSelA,
  input logic [1:0]    fwdSelB,
  input logic          pcWriteEn,
  input logic          ifIdWriteEn,
  input logic          idExBubble,
  input logic          ifIdFlush,
  input logic          pcTakeTarget
);
  p_fwd_memstg_r1: assert property (@(posedge clk) disable iff (!rstN)
    (exMemRegWrite && exMemRd != '0 && exMemRd == idExRs) |-> fwdSelA == 2'b10);

  p_fwd_wback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWbRegWrite && memWbRd != '0 && memWbRd == idExRt &&
     !(exMemRegWrite && exMemRd == idExRt)) |-> fwdSelB == 2'b01);

  p_no_fwd_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (idExRs == '0) |-> fwdSelA == 2'b00);

  p_no_fwd_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!exMemRegWrite && !memWbRegWrite) |-> (fwdSelA == 2'b00 && fwdSelB == 2'b00));

  p_load_use_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idExMemRead && idExRt != '0 && (idExRt == ifIdRs || idExRt == ifIdRt))
    |-> (!pcWriteEn && !ifIdWriteEn && idExBubble));

  p_stall_coherent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pcWriteEn == ifIdWriteEn) && (idExBubble == !pcWriteEn));

  p_no_stall_nonload_r7: assert property (@(posedge clk) disable iff (!rstN)
    !idExMemRead |-> (pcWriteEn && !idExBubble));

  p_squash_r8: assert property (@(posedge clk) disable iff (!rstN)
    (idBranchTaken && pcWriteEn) |-> (ifIdFlush && pcTakeTarget));

  p_no_squash_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pcWriteEn |-> (!ifIdFlush && !pcTakeTarget));
endmodule

bind hazardUnit hazardUnitChk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .idExRs        (idExRs),
  .idExRt        (idExRt),
  .idExMemRead   (idExMemRead),
  .exMemRd       (exMemRd),
  .exMemRegWrite (exMemRegWrite),
  .memWbRd       (memWbRd),
  .memWbRegWrite (memWbRegWrite),
  .ifIdRs        (ifIdRs),
  .ifIdRt        (ifIdRt),
  .idBranchTaken (idBranchTaken),
  .fwdSelA       (fwdSelA),
  .fwdSelB       (fwdSelB),
  .pcWriteEn     (pcWriteEn),
  .ifIdWriteEn   (ifIdWriteEn),
  .idExBubble    (idExBubble),
  .ifIdFlush     (ifIdFlush),
  .pcTakeTarget  (pcTakeTarget)
);

// File: tb/test_hazardUnit.sv
module test_hazardUnit;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] idExRs, idExRt, exMemRd, memWbRd, ifIdRs, ifIdRt;
  logic          idExMemRead, exMemRegWrite, memWbRegWrite, idBranchTaken;
  logic [1:0]    fwdSelA, fwdSelB;
  logic          pcWriteEn, ifIdWriteEn, idExBubble, ifIdFlush, pcTakeTarget;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hazardUnit #(.AW(AW)) i_hazardUnit (
    .clk(clk), .rstN(rstN),
    .idExRs(idExRs), .idExRt(idExRt), .idExMemRead(idExMemRead),
    .exMemRd(exMemRd), .exMemRegWrite(exMemRegWrite),
    .memWbRd(memWbRd), .memWbRegWrite(memWbRegWrite),
    .ifIdRs(ifIdRs), .ifIdRt(ifIdRt), .idBranchTaken(idBranchTaken),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .pcWriteEn(pcWriteEn), .ifIdWriteEn(ifIdWriteEn), .idExBubble(idExBubble),
    .ifIdFlush(ifIdFlush), .pcTakeTarget(pcTakeTarget)
  );

  task automatic check(input string req, input string what, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    idExRs = 5'd0; idExRt = 5'd0; idExMemRead = 1'b0;
    exMemRd = 5'd0; exMemRegWrite = 1'b0;
    memWbRd = 5'd0; memWbRegWrite = 1'b0;
    ifIdRs = 5'd0; ifIdRt = 5'd0; idBranchTaken = 1'b0;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic checkNoStall(input string req);
    check(req, "pcWriteEn", int'(pcWriteEn), 1);
    check(req, "ifIdWriteEn", int'(ifIdWriteEn), 1);
    check(req, "idExBubble", int'(idExBubble), 0);
  endtask

  task automatic checkStall(input string req);
    check(req, "pcWriteEn", int'(pcWriteEn), 0);
    check(req, "ifIdWriteEn", int'(ifIdWriteEn), 0);
    check(req, "idExBubble", int'(idExBubble), 1);
  endtask

  task automatic tReset();
    idle(); settle();
    check("R4", "reset fwdSelA", int'(fwdSelA), 0);
    check("R4", "reset fwdSelB", int'(fwdSelB), 0);
    checkNoStall("R7");
    check("R8", "reset ifIdFlush", int'(ifIdFlush), 0);
    check("R8", "reset pcTakeTarget", int'(pcTakeTarget), 0);
  endtask

  task automatic tFwdMem();  // R1 on operand A, R5 independence
    idle();
    idExRs = 5'd7; idExRt = 5'd9; exMemRd = 5'd7; exMemRegWrite = 1'b1;
    settle();
    check("R1", "fwdSelA mem", int'(fwdSelA), 2);
    check("R5", "fwdSelB untouched", int'(fwdSelB), 0);
    idle();
    idExRs = 5'd3; idExRt = 5'd12; exMemRd = 5'd12; exMemRegWrite = 1'b1;
    settle();
    check("R1", "fwdSelB mem", int'(fwdSelB), 2);
    check("R5", "fwdSelA untouched", int'(fwdSelA), 0);
  endtask

  task automatic tFwdWb();  // R2
    idle();
    idExRs = 5'd4; idExRt = 5'd17; memWbRd = 5'd17; memWbRegWrite = 1'b1;
    exMemRd = 5'd4; exMemRegWrite = 1'b0;
    settle();
    check("R2", "fwdSelB wb", int'(fwdSelB), 1);
    check("R4", "fwdSelA producer no write", int'(fwdSelA), 0);
    idle();
    idExRs = 5'd20; idExRt = 5'd21; memWbRd = 5'd20; memWbRegWrite = 1'b1;
    exMemRd = 5'd21; exMemRegWrite = 1'b1;
    settle();
    check("R2", "fwdSelA wb", int'(fwdSelA), 1);
    check("R5", "fwdSelB mem other", int'(fwdSelB), 2);
  endtask

  task automatic tPriority();  // R3
    idle();
    idExRs = 5'd8; idExRt = 5'd8; exMemRd = 5'd8; exMemRegWrite = 1'b1;
    memWbRd = 5'd8; memWbRegWrite = 1'b1;
    settle();
    check("R3", "fwdSelA priority", int'(fwdSelA), 2);
    check("R3", "fwdSelB priority", int'(fwdSelB), 2);
  endtask

  task automatic tZeroReg();  // R4
    idle();
    idExRs = 5'd0; idExRt = 5'd0; exMemRd = 5'd0; exMemRegWrite = 1'b1;
    memWbRd = 5'd0; memWbRegWrite = 1'b1;
    settle();
    check("R4", "fwdSelA r0", int'(fwdSelA), 0);
    check("R4", "fwdSelB r0", int'(fwdSelB), 0);
    idle();
    idExRs = 5'd31; idExRt = 5'd30; exMemRd = 5'd31; memWbRd = 5'd30;
    settle();
    check("R4", "fwdSelA no regwrite", int'(fwdSelA), 0);
    check("R4", "fwdSelB no regwrite", int'(fwdSelB), 0);
  endtask

  task automatic tLoadUse();  // R6, R7
    idle();
    idExMemRead = 1'b1; idExRt = 5'd5; ifIdRs = 5'd5; ifIdRt = 5'd6;
    settle();
    checkStall("R6");
    idle();
    idExMemRead = 1'b1; idExRt = 5'd11; ifIdRs = 5'd2; ifIdRt = 5'd11;
    settle();
    checkStall("R6");
    idle();
    idExMemRead = 1'b1; idExRt = 5'd0; ifIdRs = 5'd0; ifIdRt = 5'd0;
    settle();
    checkNoStall("R7");
    idle();
    idExMemRead = 1'b0; idExRt = 5'd5; ifIdRs = 5'd5;
    settle();
    checkNoStall("R7");
    idle();
    idExMemRead = 1'b1; idExRt = 5'd5; ifIdRs = 5'd6; ifIdRt = 5'd7;
    settle();
    checkNoStall("R7");
  endtask

  task automatic tBranch();  // R8, R9
    idle();
    idBranchTaken = 1'b1;
    settle();
    check("R8", "ifIdFlush taken", int'(ifIdFlush), 1);
    check("R8", "pcTakeTarget taken", int'(pcTakeTarget), 1);
    checkNoStall("R8");
    idle();
    idBranchTaken = 1'b0; ifIdRs = 5'd3;
    settle();
    check("R8", "ifIdFlush not taken", int'(ifIdFlush), 0);
    check("R8", "pcTakeTarget not taken", int'(pcTakeTarget), 0);
    idle();
    idBranchTaken = 1'b1; idExMemRead = 1'b1; idExRt = 5'd9; ifIdRs = 5'd9;
    settle();
    check("R9", "ifIdFlush during stall", int'(ifIdFlush), 0);
    check("R9", "pcTakeTarget during stall", int'(pcTakeTarget), 0);
    checkStall("R9");
  endtask

  task automatic tIndependence();  // R10
    idle();
    idExRs = 5'd13; idExRt = 5'd14; exMemRd = 5'd13; exMemRegWrite = 1'b1;
    memWbRd = 5'd14; memWbRegWrite = 1'b1;
    idExMemRead = 1'b1; ifIdRs = 5'd14; idBranchTaken = 1'b1;
    settle();
    check("R10", "fwdSelA under stall", int'(fwdSelA), 2);
    check("R10", "fwdSelB under stall", int'(fwdSelB), 1);
    idExMemRead = 1'b0;
    settle();
    check("R10", "fwdSelA under squash", int'(fwdSelA), 2);
    check("R10", "fwdSelB under squash", int'(fwdSelB), 1);
    check("R10", "ifIdFlush", int'(ifIdFlush), 1);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tFwdMem();
    tFwdWb();
    tPriority();
    tZeroReg();
    tLoadUse();
    tBranch();
    tIndependence();
    idle();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule